// File: doc/BRIEF.md
# Rate Sensor Power-Up Sequencer

This block brings an angular-rate sensor from power-on to a known good state. It drives a command engine that owns the serial bit timing, and it scripts the fixed bring-up conversation. First comes a long settling wait. Then it sends a sensor poll that asks the part for a self-check, followed by three plain polls with set gaps between them. The block judges the words that come back. Last, it reads the fault register pair and decides whether the part is healthy.

Delays are counted in pulses of a one-per-millisecond tick input. A bench or a fast simulation can therefore shrink them by pulsing the tick more often. The outcome shows on a ready flag or an error flag with a two-bit reason code. A separate sticky warning records an unexpected answer to the self-check poll, which is not fatal. A start pulse reruns the whole script from the long wait.

Top module: `gyro_powerup_seq`

## Requirements
- R1: After reset or a start pulse, no frame is requested until LONG_MS ticks have been counted; the first request strobe follows in the cycle after the count runs out.
- R2: The first request is a single full-duplex frame (kind 0) carrying word 0x20000003: sensor poll (bit 29), check request (bit 1) and parity (bit 0).
- R3: If the word returned by the first frame differs from 0x00000001, the warning output goes high and stays high, and the script carries on.
- R4: After each of the first two responses the block waits SHORT_MS ticks and then requests a plain sensor poll 0x20000000 (kind 0).
- R5: The fourth request strobe comes in the cycle right after the third response is accepted, with no wait.
- R6: A third or fourth response fails if its bits 7:0 ORed with 0x01 are not 0xFF or its bits 27:26 are not 2'b10; the block then stops with error code 1.
- R7: After a good fourth response the block requests frame 0x80140000 with kind 1, a register read at pair address 0x0A with bit 0 as odd parity.
- R8: If any of bits 16:5 of the fault-read response is set, the block stops with error code 2; otherwise it raises ready with code 0. Bits outside 16:5 have no effect.
- R9: A completion that reports a link failure (err input high) while a response is awaited stops the block with error code 3 in the next cycle.
- R10: A start pulse in any state clears ready, error, code and warning in the next cycle and restarts at the long wait.
- R11: Ready and error are never high together, and once either is high no further request is made until the next start.
- R12: A completion pulse arriving while no response is awaited is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart the bring-up script |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| cmd_start_o | output | 1 | One-cycle request to the command engine |
| cmd_kind_o | output | 1 | 0 = single full-duplex frame, 1 = request frame then read frame |
| cmd_word_o | output | 32 | Frame word to transmit, valid with cmd_start_o |
| cmd_done_i | input | 1 | Command engine completion pulse |
| cmd_err_i | input | 1 | Link failure, valid with cmd_done_i |
| cmd_rx_i | input | 32 | Received response word, valid with cmd_done_i |
| ready_o | output | 1 | Script finished with a healthy part |
| error_o | output | 1 | Script stopped on an error |
| err_code_o | output | 2 | 0 none, 1 response mismatch, 2 fault set, 3 link failure |
| warn_o | output | 1 | Sticky: self-check response was not 0x00000001 |

## Verification
The bench goes after each pattern check at its edge. It sends a low byte of 0xFE, which must pass because bit 0 is don't-care, and a low byte of 0xFD, which must fail. A design that checked the whole byte, or skipped the status field test at 27:26, would report ready where it should stop. A fault word with only bit 16 set must stop with code 2, and one with bits 17 and 4:0 set must pass; a design with the fault field shifted by one bit would get one of these wrong. Further cases cover a link failure on a plain poll, a stray completion during the long wait that would otherwise end in code 3, and a restart after the warning was raised. A sequencer that kept the warning across a restart, or that left a gap before the fourth poll, shows up in the per-cycle comparison.

// File: rtl/gyro_seq_pkg.sv
package gyro_seq_pkg;

    typedef enum logic [3:0] {
        S_HOLD_LONG,
        S_TX_SELF,
        S_RX_SELF,
        S_HOLD_A,
        S_TX_P1,
        S_RX_P1,
        S_HOLD_B,
        S_TX_P2,
        S_RX_P2,
        S_TX_P3,
        S_RX_P3,
        S_TX_FLT,
        S_RX_FLT,
        S_READY,
        S_FAILED
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_RESP  = 2'd1,
        ERR_FAULT = 2'd2,
        ERR_LINK  = 2'd3
    } err_code_e;

    typedef struct packed {
        seq_state_e st;
        err_code_e  code;
        logic       warn;
    } seq_regs_t;

    localparam logic [31:0] POLL_WORD    = 32'h2000_0000;
    localparam logic [31:0] CHK_BIT      = 32'h0000_0002;
    localparam logic [31:0] PAR_BIT      = 32'h0000_0001;
    localparam logic [31:0] RD_WORD      = 32'h8000_0000;
    localparam int          ADDR_POS     = 17;
    localparam logic [7:0]  FAULT_PAIR   = 8'h0A;

    // Register read frame: opcode, pair address, then bit 0 set so the
    // total number of ones in the frame is odd.
    function automatic logic [31:0] reg_read_frame(input logic [7:0] addr);
        logic [31:0] w;
        w = RD_WORD | (32'(addr) << ADDR_POS);
        if (^w == 1'b0) begin
            w = w | PAR_BIT;
        end
        return w;
    endfunction

endpackage

// File: rtl/ms_delay_timer.sv
module ms_delay_timer #(
    parameter int W        = 7,
    parameter int RST_LOAD = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         tick_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_LOAD);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && (cnt_q == '0)) |=> (cnt_q == '0)); // R1
    AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(cnt_q)); // R1

endmodule

// File: rtl/gyro_resp_check.sv
module gyro_resp_check #(
    parameter int FAULT_LSB  = 5,
    parameter int FAULT_BITS = 12
) (
    input  logic [31:0] rx_i,
    output logic        selfchk_ok_o,
    output logic        poll_ok_o,
    output logic        fault_o
);

    localparam int FAULT_MSB = FAULT_LSB + FAULT_BITS - 1;

    logic low_ok;
    logic stat_ok;

    // bit 0 of the low byte is don't-care for the poll pattern
    assign low_ok       = ((rx_i[7:0] | 8'h01) == 8'hFF);
    assign stat_ok      = (rx_i[27:26] == 2'b10);
    assign poll_ok_o    = low_ok && stat_ok;
    assign selfchk_ok_o = (rx_i == 32'h0000_0001);
    assign fault_o      = |rx_i[FAULT_MSB:FAULT_LSB];

endmodule

// File: rtl/gyro_powerup_seq.sv
module gyro_powerup_seq
    import gyro_seq_pkg::*;
#(
    parameter int LONG_MS  = 100,
    parameter int SHORT_MS = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        ms_tick_i,
    output logic        cmd_start_o,
    output logic        cmd_kind_o,
    output logic [31:0] cmd_word_o,
    input  logic        cmd_done_i,
    input  logic        cmd_err_i,
    input  logic [31:0] cmd_rx_i,
    output logic        ready_o,
    output logic        error_o,
    output logic [1:0]  err_code_o,
    output logic        warn_o
);

    localparam int MAX_MS = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
    localparam int TW     = $clog2(MAX_MS + 1);
    localparam logic [31:0] SELF_WORD  = POLL_WORD | CHK_BIT | PAR_BIT;
    localparam logic [31:0] FAULT_WORD = reg_read_frame(FAULT_PAIR);

    seq_regs_t r_q;
    seq_regs_t r_d;

    logic          arm;
    logic [TW-1:0] arm_val;
    logic          expired;
    logic          selfchk_ok;
    logic          poll_ok;
    logic          fault_set;
    logic          rx_wait;

    ms_delay_timer #(
        .W        (TW),
        .RST_LOAD (LONG_MS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (arm),
        .load_val_i (arm_val),
        .tick_i     (ms_tick_i),
        .expired_o  (expired)
    );

    gyro_resp_check #(
        .FAULT_LSB  (5),
        .FAULT_BITS (12)
    ) u_check (
        .rx_i         (cmd_rx_i),
        .selfchk_ok_o (selfchk_ok),
        .poll_ok_o    (poll_ok),
        .fault_o      (fault_set)
    );

    assign rx_wait = (r_q.st == S_RX_SELF) || (r_q.st == S_RX_P1) ||
                     (r_q.st == S_RX_P2)   || (r_q.st == S_RX_P3) ||
                     (r_q.st == S_RX_FLT);

    always_comb begin
        r_d     = r_q;
        arm     = 1'b0;
        arm_val = TW'(SHORT_MS);

        unique case (r_q.st)
            S_HOLD_LONG: if (expired) r_d.st = S_TX_SELF;
            S_TX_SELF:   r_d.st = S_RX_SELF;
            S_RX_SELF: begin
                if (cmd_done_i) begin
                    if (cmd_err_i) begin
                        r_d.st   = S_FAILED;
                        r_d.code = ERR_LINK;
                    end else begin
                        r_d.warn = r_q.warn | ~selfchk_ok;
                        r_d.st   = S_HOLD_A;
                        arm      = 1'b1;
                    end
                end
            end
            S_HOLD_A:    if (expired) r_d.st = S_TX_P1;
            S_TX_P1:     r_d.st = S_RX_P1;
            S_RX_P1: begin
                if (cmd_done_i) begin
                    if (cmd_err_i) begin
                        r_d.st   = S_FAILED;
                        r_d.code = ERR_LINK;
                    end else begin
                        r_d.st = S_HOLD_B;
                        arm    = 1'b1;
                    end
                end
            end
            S_HOLD_B:    if (expired) r_d.st = S_TX_P2;
            S_TX_P2:     r_d.st = S_RX_P2;
            S_RX_P2: begin
                if (cmd_done_i) begin
                    if (cmd_err_i) begin
                        r_d.st   = S_FAILED;
                        r_d.code = ERR_LINK;
                    end else if (!poll_ok) begin
                        r_d.st   = S_FAILED;
                        r_d.code = ERR_RESP;
                    end else begin
                        r_d.st = S_TX_P3;
                    end
                end
            end
            S_TX_P3:     r_d.st = S_RX_P3;
            S_RX_P3: begin
                if (cmd_done_i) begin
                    if (cmd_err_i) begin
                        r_d.st   = S_FAILED;
                        r_d.code = ERR_LINK;
                    end else if (!poll_ok) begin
                        r_d.st   = S_FAILED;
                        r_d.code = ERR_RESP;
                    end else begin
                        r_d.st = S_TX_FLT;
                    end
                end
            end
            S_TX_FLT:    r_d.st = S_RX_FLT;
            S_RX_FLT: begin
                if (cmd_done_i) begin
                    if (cmd_err_i) begin
                        r_d.st   = S_FAILED;
                        r_d.code = ERR_LINK;
                    end else if (fault_set) begin
                        r_d.st   = S_FAILED;
                        r_d.code = ERR_FAULT;
                    end else begin
                        r_d.st = S_READY;
                    end
                end
            end
            S_READY:     r_d.st = S_READY;
            S_FAILED:    r_d.st = S_FAILED;
            default:     r_d.st = S_FAILED;
        endcase

        if (start_i) begin
            r_d.st   = S_HOLD_LONG;
            r_d.code = ERR_NONE;
            r_d.warn = 1'b0;
            arm      = 1'b1;
            arm_val  = TW'(LONG_MS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= S_HOLD_LONG;
            r_q.code <= ERR_NONE;
            r_q.warn <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        cmd_start_o = 1'b0;
        cmd_kind_o  = 1'b0;
        cmd_word_o  = '0;
        unique case (r_q.st)
            S_TX_SELF: begin
                cmd_start_o = 1'b1;
                cmd_word_o  = SELF_WORD;
            end
            S_TX_P1, S_TX_P2, S_TX_P3: begin
                cmd_start_o = 1'b1;
                cmd_word_o  = POLL_WORD;
            end
            S_TX_FLT: begin
                cmd_start_o = 1'b1;
                cmd_kind_o  = 1'b1;
                cmd_word_o  = FAULT_WORD;
            end
            default: ;
        endcase
    end

    assign ready_o    = (r_q.st == S_READY);
    assign error_o    = (r_q.st == S_FAILED);
    assign err_code_o = r_q.code;
    assign warn_o     = r_q.warn;

    AST_READY_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && error_o)); // R11
    AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready_o || error_o) && !start_i) |=> (!cmd_start_o && (ready_o || error_o))); // R11
    AST_LINK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wait && cmd_done_i && cmd_err_i && !start_i) |=> (error_o && err_code_o == 2'd3)); // R9
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!ready_o && !error_o && !warn_o && err_code_o == 2'd0 && !cmd_start_o)); // R10
    AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (err_code_o != 2'd0)); // R6
    AST_READY_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (err_code_o == 2'd0)); // R8
    AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_o && !start_i) |=> warn_o); // R3

endmodule

// File: tb/gyro_powerup_seq_bench.sv
module gyro_powerup_seq_bench;

    localparam int LONG     = 4;
    localparam int SHORT    = 2;
    localparam int TICK_DIV = 3;
    localparam int LAT      = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        start_i;
    logic        ms_tick_i;
    logic        cmd_done_i;
    logic        cmd_err_i;
    logic [31:0] cmd_rx_i;
    logic        cmd_start_o;
    logic        cmd_kind_o;
    logic [31:0] cmd_word_o;
    logic        ready_o;
    logic        error_o;
    logic [1:0]  err_code_o;
    logic        warn_o;

    gyro_powerup_seq #(.LONG_MS(LONG), .SHORT_MS(SHORT)) u_gyro_powerup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ms_tick_i(ms_tick_i),
        .cmd_start_o(cmd_start_o), .cmd_kind_o(cmd_kind_o), .cmd_word_o(cmd_word_o),
        .cmd_done_i(cmd_done_i), .cmd_err_i(cmd_err_i), .cmd_rx_i(cmd_rx_i),
        .ready_o(ready_o), .error_o(error_o), .err_code_o(err_code_o), .warn_o(warn_o)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] rsp_word [5];
    logic        rsp_err  [5];
    int          rsp_idx   = 0;
    int          pend      = 0;
    int          frames    = 0;
    int          tick_div  = 0;
    logic        stray_req = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // command engine stand-in and millisecond tick
    initial begin
        ms_tick_i  = 1'b0;
        cmd_done_i = 1'b0;
        cmd_err_i  = 1'b0;
        cmd_rx_i   = '0;
        forever begin
            @(negedge clk);
            ms_tick_i  = (tick_div == TICK_DIV - 1);
            tick_div   = (tick_div + 1) % TICK_DIV;
            cmd_done_i = 1'b0;
            cmd_err_i  = 1'b0;
            if (stray_req) begin
                cmd_done_i = 1'b1;
                cmd_err_i  = 1'b1;
                stray_req  = 1'b0;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    cmd_done_i = 1'b1;
                    cmd_rx_i   = (rsp_idx < 5) ? rsp_word[rsp_idx] : 32'h0;
                    cmd_err_i  = (rsp_idx < 5) ? rsp_err[rsp_idx] : 1'b0;
                    rsp_idx++;
                end
            end
            if (cmd_start_o) begin
                pend = LAT;
                frames++;
            end
        end
    end

    // behavioural reference: phase of the script plus remaining ticks
    int   m_phase = 0;
    int   m_left  = LONG;
    int   m_code  = 0;
    bit   m_warn  = 1'b0;

    function automatic bit poll_good(input logic [31:0] w);
        return ((w & 32'hFF) | 32'h1) == 32'hFF && ((w >> 26) & 32'h3) == 32'h2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || start_i) begin
            m_phase = 0; m_left = LONG; m_code = 0; m_warn = 1'b0;
        end else begin
            case (m_phase)
                0, 3, 6: begin
                    if (m_left == 0) m_phase = m_phase + 1;
                    else if (ms_tick_i) m_left = m_left - 1;
                end
                1, 4, 7, 9, 11: m_phase = m_phase + 1;
                2, 5, 8, 10, 12: begin
                    if (cmd_done_i) begin
                        if (cmd_err_i) begin
                            m_phase = 14; m_code = 3;
                        end else if (m_phase == 2) begin
                            if (cmd_rx_i != 32'h1) m_warn = 1'b1;
                            m_phase = 3; m_left = SHORT;
                        end else if (m_phase == 5) begin
                            m_phase = 6; m_left = SHORT;
                        end else if (m_phase == 12) begin
                            if (((cmd_rx_i >> 5) & 32'hFFF) != 0) begin
                                m_phase = 14; m_code = 2;
                            end else m_phase = 13;
                        end else if (!poll_good(cmd_rx_i)) begin
                            m_phase = 14; m_code = 1;
                        end else m_phase = m_phase + 1;
                    end
                end
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        bit          e_start;
        logic [31:0] e_word;
        bit          e_kind;
        e_start = (m_phase == 1) || (m_phase == 4) || (m_phase == 7) ||
                  (m_phase == 9) || (m_phase == 11);
        e_word  = (m_phase == 1) ? 32'h2000_0003 :
                  (m_phase == 11) ? 32'h8014_0000 : 32'h2000_0000;
        e_kind  = (m_phase == 11);
        chk(cmd_start_o == e_start, "R1/R4/R5 request strobe", 32'(cmd_start_o), 32'(e_start));
        if (e_start) begin
            chk(cmd_word_o == e_word, "R2/R4/R7 request word", cmd_word_o, e_word);
            chk(cmd_kind_o == e_kind, "R2/R7 request kind", 32'(cmd_kind_o), 32'(e_kind));
        end
        chk({ready_o, error_o, err_code_o, warn_o} ==
            {m_phase == 13, m_phase == 14, 2'(m_code), m_warn},
            "R3/R6/R8/R9/R11 status", {27'd0, ready_o, error_o, err_code_o, warn_o},
            {27'd0, m_phase == 13, m_phase == 14, 2'(m_code), m_warn});
    end

    task automatic load_script(input logic [31:0] w0, w1, w2, w3, w4, input logic [4:0] e);
        rsp_word[0] = w0; rsp_word[1] = w1; rsp_word[2] = w2;
        rsp_word[3] = w3; rsp_word[4] = w4;
        for (int i = 0; i < 5; i++) rsp_err[i] = e[i];
    endtask

    task automatic restart();
        @(negedge clk); #1;
        rsp_idx = 0; pend = 0; frames = 0; start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (ready_o || error_o) break;
        end
        #1;
    endtask

    task automatic expect_end(input string tag, input bit rdy, input int code, input bit wrn, input int nfr);
        chk(ready_o == rdy, {tag, " ready"}, 32'(ready_o), 32'(rdy));
        chk(err_code_o == 2'(code), {tag, " code"}, 32'(err_code_o), 32'(code));
        chk(warn_o == wrn, {tag, " warn"}, 32'(warn_o), 32'(wrn));
        chk(frames == nfr, {tag, " frame count"}, 32'(frames), 32'(nfr));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        start_i = 1'b0;
        load_script(32'h1, 32'h0, 32'h0800_00FE, 32'h0800_00FF, 32'hFFFE_001F, 5'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!cmd_start_o && !ready_o && !error_o && !warn_o, "R1 reset state",
            {28'd0, cmd_start_o, ready_o, error_o, warn_o}, 32'd0);

        // nominal run from reset: bit 0 don't-care, fault bits outside 16:5 set
        wait_end();
        expect_end("R8 nominal", 1'b1, 0, 1'b0, 5);
        repeat (20) @(negedge clk);
        #1;
        chk(frames == 5 && ready_o, "R11 quiet after ready", 32'(frames), 32'd5);

        // self-check mismatch only warns
        load_script(32'h0, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 32'h0, 5'b0);
        restart();
        wait_end();
        expect_end("R3 warning", 1'b1, 0, 1'b1, 5);

        // third response low byte wrong
        load_script(32'h1, 32'h0, 32'h0800_00FD, 32'h0800_00FF, 32'h0, 5'b0);
        restart();
        wait_end();
        expect_end("R6 low byte", 1'b0, 1, 1'b0, 3);
        repeat (20) @(negedge clk);
        #1;
        chk(frames == 3 && error_o, "R11 quiet after error", 32'(frames), 32'd3);

        // fourth response status field wrong
        load_script(32'h1, 32'h0, 32'h0800_00FF, 32'h0C00_00FF, 32'h0, 5'b0);
        restart();
        wait_end();
        expect_end("R6 status field", 1'b0, 1, 1'b0, 4);

        // fault bit at top of field
        load_script(32'h1, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 32'h0001_0000, 5'b0);
        restart();
        wait_end();
        expect_end("R8 fault set", 1'b0, 2, 1'b0, 5);

        // fault bit at bottom of field
        load_script(32'h1, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 32'h0000_0020, 5'b0);
        restart();
        wait_end();
        expect_end("R8 fault low bit", 1'b0, 2, 1'b0, 5);

        // link failure on the second poll
        load_script(32'h1, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 32'h0, 5'b00010);
        restart();
        wait_end();
        expect_end("R9 link failure", 1'b0, 3, 1'b0, 2);

        // restart mid-script after a warning
        load_script(32'h5, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 32'h0, 5'b0);
        restart();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (frames >= 2) break;
        end
        #1;
        chk(warn_o == 1'b1, "R3 warning raised before restart", 32'(warn_o), 32'd1);
        load_script(32'h1, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 32'h0, 5'b0);
        restart();
        chk(warn_o == 1'b0 && !cmd_start_o, "R10 restart clears", 32'(warn_o), 32'd0);
        wait_end();
        expect_end("R10 rerun", 1'b1, 0, 1'b0, 5);

        // stray completion with link error during the long wait
        load_script(32'h1, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 32'h0, 5'b0);
        restart();
        @(negedge clk); #1;
        stray_req = 1'b1;
        wait_end();
        expect_end("R12 stray completion", 1'b1, 0, 1'b0, 5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule